// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block provides two programmable interval timers for the register interface of a sound generator. The host writes bytes over a simple address/data/strobe port. Three timer-value registers hold the reload counts. One control register starts and stops each timer, decides whether each overflow may raise its status flag, clears flags with write-one strobes, and carries a two-bit channel-3 mode field. The block decodes that field and exports it.

Both timers count up from their programmed value on each cycle where the `tick` input is high. Timer A advances on every tick. Timer B advances once per sixteen ticks, through an internal prescaler. When a counter at all-ones receives a step, it overflows and reloads its programmed value. Its flag is latched into a status byte, and an interrupt-style output is the OR of the two flags.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, `status` is 0x00, `irq` is 0, `ch3_mode` is 0 and both timers are stopped.
- R2: The timer A reload value is 10 bits. Bits 9..2 come from a write to address 0x24, and bits 1..0 come from data bits 1..0 of a write to address 0x25. The timer B reload value is the full 8-bit byte written to address 0x26.
- R3: In a write to control address 0x27, data bit 0 sets timer A running (1) or stopped (0), and data bit 1 does the same for timer B. A stopped timer never overflows.
- R4: A running timer increments on each step. A step that finds the counter at all-ones is an overflow and reloads the programmed value. Timer A therefore overflows every 1024 − value ticks.
- R5: Starting a stopped timer loads its counter from the programmed value. A value written while the timer runs is used only at that timer's next reload.
- R6: Timer B steps once every 16 ticks. Its 4-bit prescaler is cleared whenever timer B is started, so timer B overflows every 16·(256 − value) ticks after a start.
- R7: Control data bit 2 (timer A) and bit 3 (timer B) let an overflow set that timer's flag. While the bit is 0, an overflow leaves the flag unchanged.
- R8: Control data bit 4 written as 1 clears the timer A flag, and bit 5 written as 1 clears the timer B flag. Writing 0 to these bits leaves the flags as they are. A clear wins over an overflow in the same cycle.
- R9: `status` bit 0 is the timer A flag and bit 1 is the timer B flag. Bits 7..2 are 0. `irq` is high exactly when either flag is set.
- R10: Control data bits 7..6 are exported on `ch3_mode`. Value 1 selects special mode. The illegal values 2 and 3 are reported as 0 (normal).
- R11: Writes to any address other than 0x24, 0x25, 0x26 and 0x27 change no timer state, flag or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Prescaled timer tick, one cycle per step |
| status | output | 8 | Flag byte: bit 0 timer A, bit 1 timer B |
| irq | output | 1 | High while any flag is set |
| ch3_mode | output | 2 | Decoded channel-3 mode (0 normal, 1 special) |

## Verification
The bench times overflow periods tick by tick, checking one tick before and at the expected overflow. An off-by-one in the wrap, or a reload taken from the wrong value, shifts the flag by a cycle. It writes a new reload value mid-run and checks that the current period is unaffected while the next one changes. It stops timer B partway through a prescaler cycle and restarts it; a prescaler that is not cleared would overflow about ten ticks early. It lands a clear strobe on the exact cycle of an overflow, where wrong priority would leave the flag set. It also checks that flag-enable 0, zero-valued clear bits, illegal mode codes and stray addresses cannot disturb the flags or the mode.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ADR_TA_HI = 8'h24;
  localparam logic [BYTE_W-1:0] ADR_TA_LO = 8'h25;
  localparam logic [BYTE_W-1:0] ADR_TB    = 8'h26;
  localparam logic [BYTE_W-1:0] ADR_CTRL  = 8'h27;

  // bit positions inside the control byte
  localparam int unsigned CB_RUN_A = 0;
  localparam int unsigned CB_RUN_B = 1;
  localparam int unsigned CB_EN_A  = 2;
  localparam int unsigned CB_EN_B  = 3;
  localparam int unsigned CB_CLR_A = 4;
  localparam int unsigned CB_CLR_B = 5;
  localparam int unsigned CB_MODE  = 6;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_SPECIAL = 2'd1
  } ch3_mode_e;

  typedef struct packed {
    logic [1:0] run;
    logic [1:0] flag_en;
    logic [1:0] clr;
    logic [1:0] start;
  } tmr_ctl_t;
endpackage

// File: rtl/dtu_regs.sv
module dtu_regs
  import dtu_pkg::*;
#(
  parameter int unsigned TA_W = 10,
  parameter int unsigned TB_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [TA_W-1:0]   load_a,
  output logic [TB_W-1:0]   load_b,
  output tmr_ctl_t          ctl,
  output logic [1:0]        ch3_mode
);
  localparam int unsigned TA_LO_W = TA_W - BYTE_W;

  logic [BYTE_W-1:0]  ta_hi_q;
  logic [TA_LO_W-1:0] ta_lo_q;
  logic [TB_W-1:0]    tb_q;
  logic [1:0]         run_q;
  logic [1:0]         en_q;
  logic [1:0]         mode_q;
  logic               ctl_wr;
  logic [1:0]         mode_d;

  assign ctl_wr = wr_en && (wr_addr == ADR_CTRL);

  always_comb begin
    mode_d = wr_data[CB_MODE +: 2];
    if (mode_d[1]) mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ta_hi_q <= '0;
      ta_lo_q <= '0;
      tb_q    <= '0;
      run_q   <= '0;
      en_q    <= '0;
      mode_q  <= MODE_NORMAL;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_TA_HI: ta_hi_q <= wr_data;
        ADR_TA_LO: ta_lo_q <= wr_data[TA_LO_W-1:0];
        ADR_TB:    tb_q    <= wr_data[TB_W-1:0];
        ADR_CTRL: begin
          run_q  <= {wr_data[CB_RUN_B], wr_data[CB_RUN_A]};
          en_q   <= {wr_data[CB_EN_B], wr_data[CB_EN_A]};
          mode_q <= mode_d;
        end
        default: ;
      endcase
    end
  end

  assign load_a      = {ta_hi_q, ta_lo_q};
  assign load_b      = tb_q;
  assign ctl.run     = run_q;
  assign ctl.flag_en = en_q;
  assign ctl.clr     = ctl_wr ? {wr_data[CB_CLR_B], wr_data[CB_CLR_A]} : 2'b00;
  assign ctl.start   = ctl_wr ? ({wr_data[CB_RUN_B], wr_data[CB_RUN_A]} & ~run_q) : 2'b00;
  assign ch3_mode    = mode_q;

  AST_MODE_SPECIAL: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[7:6] == 2'b01) |=> (ch3_mode == 2'b01)); // R10
  AST_MODE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[7]) |=> (ch3_mode == 2'b00)); // R10
  AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctl.run == $past(wr_data[1:0]))); // R3
  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[7:2] != 6'b001001) |=> ($stable(ch3_mode) && $stable(load_a) && $stable(load_b) && $stable(ctl.run))); // R11
endmodule

// File: rtl/dtu_presc.sv
module dtu_presc #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic step
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear)      pre_q <= '0;
    else if (run && tick)  pre_q <= pre_q + 1'b1;
  end

  assign step = run && tick && (pre_q == {PRE_W{1'b1}});

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0)); // R6
endmodule

// File: rtl/dtu_count.sv
module dtu_count #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] load,
  output logic         ovf
);
  logic [W-1:0] cnt_q;

  assign ovf = run && step && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (start || ovf)   cnt_q <= load;
    else if (run && step)    cnt_q <= cnt_q + 1'b1;
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(load))); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt_q == $past(load))); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/dtu_flags.sv
module dtu_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag,
  output logic         irq
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag[i];
      if (clr[i])                flag_d[i] = 1'b0;
      else if (ovf[i] && en[i])  flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) flag[i] <= 1'b0;
      else     flag[i] <= flag_d[i];
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      clr[i] |=> !flag[i]); // R8
    AST_GATED_SET: assert property (@(posedge clk) disable iff (rst)
      (!flag[i] && !(ovf[i] && en[i])) |=> !flag[i]); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |flag_d;
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (|flag))); // R9
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int unsigned TA_W  = 10,
  parameter int unsigned TB_W  = 8,
  parameter int unsigned PRE_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        tick,
  output logic [7:0]  status,
  output logic        irq,
  output logic [1:0]  ch3_mode
);
  localparam int unsigned NTMR = 2;

  logic [TA_W-1:0] load_a;
  logic [TB_W-1:0] load_b;
  tmr_ctl_t        ctl;
  logic            step_b;
  logic [NTMR-1:0] ovf;
  logic [NTMR-1:0] flag;

  dtu_regs #(.TA_W(TA_W), .TB_W(TB_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_a(load_a), .load_b(load_b), .ctl(ctl), .ch3_mode(ch3_mode)
  );

  dtu_count #(.W(TA_W)) u_cnt_a (
    .clk(clk), .rst(rst), .start(ctl.start[0]), .run(ctl.run[0]),
    .step(tick), .load(load_a), .ovf(ovf[0])
  );

  dtu_presc #(.PRE_W(PRE_W)) u_presc_b (
    .clk(clk), .rst(rst), .clear(ctl.start[1]), .run(ctl.run[1]),
    .tick(tick), .step(step_b)
  );

  dtu_count #(.W(TB_W)) u_cnt_b (
    .clk(clk), .rst(rst), .start(ctl.start[1]), .run(ctl.run[1]),
    .step(step_b), .load(load_b), .ovf(ovf[1])
  );

  dtu_flags #(.N(NTMR)) u_flags (
    .clk(clk), .rst(rst), .ovf(ovf), .en(ctl.flag_en), .clr(ctl.clr),
    .flag(flag), .irq(irq)
  );

  assign status = {{(8-NTMR){1'b0}}, flag};

  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    status[7:2] == '0); // R9
  AST_STOPPED_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (!ctl.run[0] |-> !ovf[0]) and (!ctl.run[1] |-> !ovf[1])); // R3
endmodule

// File: tb/dual_timer_unit_bench.sv
module dual_timer_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] status;
  logic       irq;
  logic [1:0] ch3_mode;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_timer_unit u_dual_timer_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .status(status), .irq(irq), .ch3_mode(ch3_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 mode", ch3_mode, 0);
    ticks(5);
    check("R1 stopped after reset", status, 8'h00);
  endtask

  task automatic t_timer_a_period();
    wr(8'h24, 8'hFF); wr(8'h25, 8'hFC);   // value 1020
    wr(8'h27, 8'h05);
    ticks(3);
    check("R2 R4 A before overflow", status[0], 0);
    ticks(1);
    check("R4 A overflow at 4 ticks", status[0], 1);
    check("R9 status byte A", status, 8'h01);
    check("R9 irq", irq, 1);
  endtask

  task automatic t_enable_off();
    wr(8'h27, 8'h11);
    check("R8 clear A", status[0], 0);
    ticks(8);
    check("R7 enable off keeps flag", status[0], 0);
  endtask

  task automatic t_clear_priority();
    wr(8'h27, 8'h30);
    wr(8'h27, 8'h05);
    ticks(3);
    wr(8'h27, 8'h15, 1'b1);                // overflow and clear together
    check("R8 clear beats overflow", status[0], 0);
    check("R9 irq low", irq, 0);
    ticks(3);
    check("R4 after same-cycle reload", status[0], 0);
    ticks(1);
    check("R4 next overflow", status[0], 1);
    wr(8'h27, 8'h05);
    check("R8 zero clear bit no effect", status[0], 1);
  endtask

  task automatic t_reload_deferred();
    wr(8'h27, 8'h30);
    wr(8'h27, 8'h05);
    ticks(2);
    wr(8'h24, 8'hFE);                      // value 1016, used only at reload
    ticks(1);
    check("R5 running value kept", status[0], 0);
    ticks(1);
    check("R5 old period honoured", status[0], 1);
    wr(8'h27, 8'h15);
    ticks(7);
    check("R5 new period not yet", status[0], 0);
    ticks(1);
    check("R5 new period after reload", status[0], 1);
  endtask

  task automatic t_stop_start();
    wr(8'h27, 8'h14);
    ticks(20);
    check("R3 stopped A no overflow", status[0], 0);
    wr(8'h27, 8'h05);
    ticks(7);
    check("R5 start reloads", status[0], 0);
    ticks(1);
    check("R5 start reload period", status[0], 1);
  endtask

  task automatic t_timer_b();
    wr(8'h26, 8'hFE);
    wr(8'h27, 8'h3A);
    check("R8 clear both", status, 8'h00);
    ticks(31);
    check("R6 B before 32 ticks", status[1], 0);
    ticks(1);
    check("R6 B overflow at 32 ticks", status[1], 1);
    check("R9 status byte B", status, 8'h02);
    wr(8'h27, 8'h38);
    wr(8'h27, 8'h3A);
    ticks(10);
    wr(8'h27, 8'h38);
    wr(8'h27, 8'h3A);
    ticks(31);
    check("R6 prescaler cleared on start", status[1], 0);
    ticks(1);
    check("R6 B overflow after restart", status[1], 1);
    wr(8'h27, 8'h08);
    check("R8 zero clear B no effect", status[1], 1);
  endtask

  task automatic t_mode_and_stray();
    wr(8'h27, 8'h48);
    check("R10 special mode", ch3_mode, 1);
    wr(8'h28, 8'hFF);
    wr(8'h23, 8'h00);
    check("R11 stray write mode", ch3_mode, 1);
    check("R11 stray write flags", status, 8'h02);
    wr(8'h27, 8'h88);
    check("R10 value 2 normal", ch3_mode, 0);
    wr(8'h27, 8'h48);
    wr(8'h27, 8'hC8);
    check("R10 value 3 normal", ch3_mode, 0);
    wr(8'h27, 8'h08);
    check("R10 value 0 normal", ch3_mode, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timer_a_period();
    t_enable_off();
    t_clear_priority();
    t_reload_deferred();
    t_stop_start();
    t_timer_b();
    t_mode_and_stray();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule